// File: doc/BRIEF.md
# DMA Cache-Line Request Splitter

This block takes a single DMA transfer (a start byte address, a byte count, a direction flag and, for writes, the payload) and turns it into a series of line-sized requests toward a memory or directory port. Each request carries the byte address it starts at, the same address with the in-line bits cleared, the byte offset within the line, the number of bytes it covers, its direction, and a full line of data.

Only the first piece of a transfer can begin in the middle of a line, and it stops at the line boundary. Every later piece starts on a line boundary. For a read, the memory side returns a whole line. The block extracts the bytes it asked for, writes them into its transfer buffer and then issues the next piece. For a write, the next piece goes out once the acknowledge arrives. When every byte is complete, the block raises a one-cycle done pulse and becomes idle again. A transfer of zero bytes finishes without issuing anything.

Top module: `dmaLineSplitter`

## Requirements
- R1: `xferReady` is high exactly while the block is idle. A transfer is taken on a cycle where `xferValid` and `xferReady` are both high. If its length is non-zero, `busy` is high from the next cycle. A transfer offered while busy is held off and is taken in the first idle cycle.
- R2: The first request of a transfer has `reqPhysAddr` equal to the start address and `reqOffset` equal to the start address ANDed with (line bytes − 1). On every request, `reqLineAddr` is `reqPhysAddr` with its low LINE_BITS bits forced to zero.
- R3: The first request's `reqLen` is the whole transfer length when offset + length ≤ line bytes. Otherwise it is line bytes − offset.
- R4: Each later request has `reqPhysAddr` = start + bytes already completed, which is line-aligned, with `reqOffset` = 0. Its `reqLen` is the smaller of the remaining bytes and the line size.
- R5: For a write, payload byte n is taken from `xferData[8n+:8]`. A request covering transfer bytes d..d+len−1 places payload byte d+i at line byte `reqOffset`+i of `reqData`. All other line bytes are zero.
- R6: For a read, the returned line (`rspData`, line byte j at bits 8j+:8, accepted only with `rspIsData`=1) provides `reqLen` bytes starting at line byte `reqOffset`. These go into transfer bytes d onward of `xferBuf`, where byte n sits at bits 8n+:8. The result is complete in the cycle of the done pulse.
- R7: At most one request is outstanding. `reqValid` falls in the cycle after a request is accepted and stays low until the response has been taken. `rspReady` is high only while a response is awaited.
- R8: While `reqValid` is high and `reqReady` is low, every request field holds its value.
- R9: After the response to the last request, `donePulse` is high for exactly one cycle, and in that same cycle `busy` is low.
- R10: A zero-length transfer raises `donePulse` in the cycle after it is taken. No request is issued and `busy` stays low.
- R11: `reqWrite` equals the transfer's direction flag on every request (1 = write). The expected response type is `rspIsData`=1 for reads and 0 (acknowledge) for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferValid | input | 1 | Transfer offered |
| xferReady | output | 1 | Block idle, transfer can be taken |
| xferAddr | input | ADDR_W | Transfer start byte address |
| xferLen | input | LEN_W | Transfer length in bytes (≤ MAX_BYTES) |
| xferWrite | input | 1 | 1 = write, 0 = read |
| xferData | input | 8·MAX_BYTES | Write payload, byte n at bits 8n+:8 |
| busy | output | 1 | Transfer in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| xferBuf | output | 8·MAX_BYTES | Transfer buffer; read result |
| reqValid | output | 1 | Line request presented |
| reqReady | input | 1 | Line request taken |
| reqPhysAddr | output | ADDR_W | Byte address of the request |
| reqLineAddr | output | ADDR_W | Line-aligned address |
| reqOffset | output | LINE_BITS | Byte offset within the line |
| reqLen | output | LINE_BITS+1 | Bytes covered by the request |
| reqWrite | output | 1 | Request direction |
| reqData | output | 8·2^LINE_BITS | Write line data |
| rspValid | input | 1 | Response presented |
| rspReady | output | 1 | Response awaited |
| rspIsData | input | 1 | 1 = line data, 0 = acknowledge |
| rspData | input | 8·2^LINE_BITS | Returned line |

## Verification
Two of this block's actions can happen in the same cycle: the completion of one transfer (done pulse, read result final) and the intake of the next transfer. The bench keeps a second transfer offered while the first is still running. It checks that the second is held off and that the read result is correct in the done cycle. It then checks that the second transfer is taken on that very edge, shown by `busy` high and its own first request on the following cycle, with no loss of the earlier result or of the new payload.

// File: rtl/dmaSplitPkg.sv
package dmaSplitPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } splitState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // transfer taken: latch descriptor and payload
    logic issued;  // request handshake done: advance issued count
    logic landed;  // response taken: advance completed count, land data
  } dpStrobe_t;

endpackage

// File: rtl/dmaSplitCtrl.sv
module dmaSplitCtrl
  import dmaSplitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferValid,
  input  logic       lenZero,
  input  logic       lastChunk,
  input  logic       reqReady,
  input  logic       rspValid,
  output logic       xferReady,
  output logic       reqValid,
  output logic       rspReady,
  output logic       busy,
  output logic       donePulse,
  output dpStrobe_t  strobe
);

  splitState_e state, stateNext;
  logic accept;

  assign xferReady = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign reqValid  = (state == ST_ISSUE);
  assign rspReady  = (state == ST_WAIT);
  assign accept    = xferValid && xferReady;

  always_comb begin
    strobe.load   = accept;
    strobe.issued = reqValid && reqReady;
    strobe.landed = rspReady && rspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept && !lenZero) stateNext = ST_ISSUE;
      ST_ISSUE: if (reqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (rspValid) stateNext = lastChunk ? ST_IDLE : ST_ISSUE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      donePulse <= (accept && lenZero) || (strobe.landed && lastChunk);
    end
  end

endmodule

// File: rtl/dmaSplitData.sv
module dmaSplitData
  import dmaSplitPkg::*;
#(
  parameter int LINE_BITS = 6,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]             xferAddr,
  input  logic [LEN_W-1:0]              xferLen,
  input  logic                          xferWrite,
  input  logic [MAX_BYTES*8-1:0]        xferData,
  input  logic                          rspIsData,
  input  logic [(8<<LINE_BITS)-1:0]     rspData,
  output logic                          lenZero,
  output logic                          lastChunk,
  output logic [ADDR_W-1:0]             reqPhysAddr,
  output logic [ADDR_W-1:0]             reqLineAddr,
  output logic [LINE_BITS-1:0]          reqOffset,
  output logic [LINE_BITS:0]            reqLen,
  output logic                          reqWrite,
  output logic [(8<<LINE_BITS)-1:0]     reqData,
  output logic [MAX_BYTES*8-1:0]        xferBuf
);

  localparam int LINE_BYTES = 1 << LINE_BITS;
  localparam int BUF_W      = $clog2(MAX_BYTES);
  localparam int CLEN_W     = LINE_BITS + 1;

  logic [ADDR_W-1:0]    startAddr;
  logic [LEN_W-1:0]     totalLen;
  logic [LEN_W-1:0]     bytesIssued;
  logic [LEN_W-1:0]     bytesDone;
  logic                 isWrite;
  logic [7:0]           xferMem [MAX_BYTES];
  logic [7:0]           rspBytes [LINE_BYTES];

  logic                 firstChunk;
  logic [LEN_W-1:0]     remaining;
  logic [LINE_BITS-1:0] offNow;
  logic [CLEN_W-1:0]    room;
  logic [CLEN_W-1:0]    chunkLen;
  logic [ADDR_W-1:0]    physNow;

  // ---------------- chunk geometry ----------------
  assign firstChunk = (bytesDone == '0);
  assign remaining  = totalLen - bytesDone;
  assign offNow     = firstChunk ? startAddr[LINE_BITS-1:0] : '0;
  assign room       = CLEN_W'(LINE_BYTES) - {1'b0, offNow};
  assign chunkLen   = (remaining <= LEN_W'(room)) ? remaining[CLEN_W-1:0] : room;
  assign physNow    = startAddr + ADDR_W'(bytesDone);

  assign lenZero    = (xferLen == '0);
  assign lastChunk  = (bytesIssued == totalLen);

  assign reqPhysAddr = physNow;
  assign reqLineAddr = {physNow[ADDR_W-1:LINE_BITS], {LINE_BITS{1'b0}}};
  assign reqOffset   = offNow;
  assign reqLen      = chunkLen;
  assign reqWrite    = isWrite;

  // ---------------- write line assembly ----------------
  always_comb begin
    reqData = '0;
    for (int j = 0; j < LINE_BYTES; j++) begin
      int rel;
      rel = j - int'(offNow);
      if (isWrite && rel >= 0 && rel < int'(chunkLen))
        reqData[j*8 +: 8] = xferMem[BUF_W'(int'(bytesDone) + rel)];
    end
  end

  always_comb begin
    for (int j = 0; j < LINE_BYTES; j++) rspBytes[j] = rspData[j*8 +: 8];
  end

  always_comb begin
    for (int k = 0; k < MAX_BYTES; k++) xferBuf[k*8 +: 8] = xferMem[k];
  end

  // ---------------- descriptor and counters ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr   <= '0;
      totalLen    <= '0;
      bytesIssued <= '0;
      bytesDone   <= '0;
      isWrite     <= 1'b0;
    end else if (strobe.load) begin
      startAddr   <= xferAddr;
      totalLen    <= xferLen;
      bytesIssued <= '0;
      bytesDone   <= '0;
      isWrite     <= xferWrite;
    end else begin
      if (strobe.issued) bytesIssued <= bytesIssued + LEN_W'(chunkLen);
      if (strobe.landed) bytesDone   <= bytesIssued;
    end
  end

  // ---------------- transfer buffer ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < MAX_BYTES; k++) xferMem[k] <= '0;
    end else if (strobe.load) begin
      for (int k = 0; k < MAX_BYTES; k++) xferMem[k] <= xferData[k*8 +: 8];
    end else if (strobe.landed && !isWrite && rspIsData) begin
      for (int k = 0; k < MAX_BYTES; k++) begin
        if (k >= int'(bytesDone) && k < int'(bytesIssued))
          xferMem[k] <= rspBytes[LINE_BITS'(k - int'(bytesDone) + int'(offNow))];
      end
    end
  end

endmodule

// File: rtl/dmaLineSplitter.sv
module dmaLineSplitter
  import dmaSplitPkg::*;
#(
  parameter int LINE_BITS = 6,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          xferValid,
  output logic                          xferReady,
  input  logic [ADDR_W-1:0]             xferAddr,
  input  logic [LEN_W-1:0]              xferLen,
  input  logic                          xferWrite,
  input  logic [MAX_BYTES*8-1:0]        xferData,
  output logic                          busy,
  output logic                          donePulse,
  output logic [MAX_BYTES*8-1:0]        xferBuf,
  output logic                          reqValid,
  input  logic                          reqReady,
  output logic [ADDR_W-1:0]             reqPhysAddr,
  output logic [ADDR_W-1:0]             reqLineAddr,
  output logic [LINE_BITS-1:0]          reqOffset,
  output logic [LINE_BITS:0]            reqLen,
  output logic                          reqWrite,
  output logic [(8<<LINE_BITS)-1:0]     reqData,
  input  logic                          rspValid,
  output logic                          rspReady,
  input  logic                          rspIsData,
  input  logic [(8<<LINE_BITS)-1:0]     rspData
);

  dpStrobe_t strobe;
  logic      lenZero;
  logic      lastChunk;

  dmaSplitCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xferValid (xferValid),
    .lenZero   (lenZero),
    .lastChunk (lastChunk),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .xferReady (xferReady),
    .reqValid  (reqValid),
    .rspReady  (rspReady),
    .busy      (busy),
    .donePulse (donePulse),
    .strobe    (strobe)
  );

  dmaSplitData #(
    .LINE_BITS (LINE_BITS),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_BYTES (MAX_BYTES)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .xferAddr    (xferAddr),
    .xferLen     (xferLen),
    .xferWrite   (xferWrite),
    .xferData    (xferData),
    .rspIsData   (rspIsData),
    .rspData     (rspData),
    .lenZero     (lenZero),
    .lastChunk   (lastChunk),
    .reqPhysAddr (reqPhysAddr),
    .reqLineAddr (reqLineAddr),
    .reqOffset   (reqOffset),
    .reqLen      (reqLen),
    .reqWrite    (reqWrite),
    .reqData     (reqData),
    .xferBuf     (xferBuf)
  );

endmodule

// File: rtl/dmaSplitChecker.sv
module dmaSplitChecker #(
  parameter int LINE_BITS = 6,
  parameter int ADDR_W    = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      xferValid,
  input logic                      xferReady,
  input logic                      busy,
  input logic                      donePulse,
  input logic                      reqValid,
  input logic                      reqReady,
  input logic [ADDR_W-1:0]         reqPhysAddr,
  input logic [LINE_BITS-1:0]      reqOffset,
  input logic [LINE_BITS:0]        reqLen,
  input logic                      reqWrite,
  input logic [(8<<LINE_BITS)-1:0] reqData,
  input logic                      rspReady
);

  localparam int LINE_BYTES = 1 << LINE_BITS;

  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    xferValid && xferReady |=> busy || donePulse) else $error("AST_ACCEPT_TAKES"); // R1

  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != '0) && ({1'b0, reqOffset} + reqLen <= (LINE_BITS+1)'(LINE_BYTES)))
    else $error("AST_CHUNK_FITS"); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid) else $error("AST_ONE_OUTSTANDING"); // R7

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqPhysAddr) && $stable(reqLen)
      && $stable(reqOffset) && $stable(reqWrite) && $stable(reqData))
    else $error("AST_REQ_STABLE"); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy && !reqValid) else $error("AST_DONE_IDLE"); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse && !$past(xferValid && xferReady) |=> !donePulse) else $error("AST_DONE_SINGLE"); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid && !rspReady) else $error("AST_IDLE_QUIET"); // R10

endmodule

bind dmaLineSplitter dmaSplitChecker #(
  .LINE_BITS (LINE_BITS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .xferValid   (xferValid),
  .xferReady   (xferReady),
  .busy        (busy),
  .donePulse   (donePulse),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqPhysAddr (reqPhysAddr),
  .reqOffset   (reqOffset),
  .reqLen      (reqLen),
  .reqWrite    (reqWrite),
  .reqData     (reqData),
  .rspReady    (rspReady)
);

// File: tb/dmaLineSplitter_tb.sv
`timescale 1ns/1ps
module dmaLineSplitter_tb;

  localparam int LB   = 6;
  localparam int LINE = 1 << LB;
  localparam int AW   = 32;
  localparam int LW   = 16;
  localparam int MAXB = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xferValid = 1'b0;
  logic xferReady;
  logic [AW-1:0] xferAddr = '0;
  logic [LW-1:0] xferLen = '0;
  logic xferWrite = 1'b0;
  logic [MAXB*8-1:0] xferData = '0;
  logic busy, donePulse;
  logic [MAXB*8-1:0] xferBuf;
  logic reqValid;
  logic reqReady = 1'b0;
  logic [AW-1:0] reqPhysAddr, reqLineAddr;
  logic [LB-1:0] reqOffset;
  logic [LB:0] reqLen;
  logic reqWrite;
  logic [LINE*8-1:0] reqData;
  logic rspValid = 1'b0;
  logic rspReady;
  logic rspIsData = 1'b0;
  logic [LINE*8-1:0] rspData = '0;

  always #2.5 clk = ~clk;

  dmaLineSplitter #(.LINE_BITS(LB), .ADDR_W(AW), .LEN_W(LW), .MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferReady(xferReady),
    .xferAddr(xferAddr), .xferLen(xferLen), .xferWrite(xferWrite), .xferData(xferData),
    .busy(busy), .donePulse(donePulse), .xferBuf(xferBuf),
    .reqValid(reqValid), .reqReady(reqReady), .reqPhysAddr(reqPhysAddr),
    .reqLineAddr(reqLineAddr), .reqOffset(reqOffset), .reqLen(reqLen),
    .reqWrite(reqWrite), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspIsData(rspIsData), .rspData(rspData)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] memModel [4096];
  logic [7:0] pay [MAXB];
  logic [7:0] snapLo, snapHi;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Present descriptor and payload on the transfer inputs
  task automatic setXfer(input int addr, input int len, input bit wr, input int seed);
    for (int i = 0; i < MAXB; i++) begin
      pay[i] = 8'(i * 13 + seed);
      xferData[i*8 +: 8] = pay[i];
    end
    xferAddr  = AW'(addr);
    xferLen   = LW'(len);
    xferWrite = wr;
    snapLo    = memModel[12'(addr - 1)];
    snapHi    = memModel[12'(addr + len)];
    xferValid = 1'b1;
  endtask

  task automatic startXfer(input int addr, input int len, input bit wr, input int seed);
    @(negedge clk);
    setXfer(addr, len, wr, seed);
    chk(xferReady, "R1", "ready while idle", longint'(xferReady), 1);
    @(negedge clk);
    xferValid = 1'b0;
    if (len != 0) chk(busy, "R1", "busy after accept", longint'(busy), 1);
  endtask

  // Serve every chunk of a running transfer and check it
  task automatic serveAll(input int addr, input int len, input bit wr,
                          input int stall, input int gap);
    int doneB, off, rem, clen, waitN, bad, lineA;
    logic [AW-1:0] sPhys;
    logic [LB:0] sLen;
    logic [LINE*8-1:0] sData;
    doneB = 0;
    while (doneB < len) begin
      off = (doneB == 0) ? (addr % LINE) : 0;
      rem = len - doneB;
      if (doneB == 0) clen = (off + len <= LINE) ? len : LINE - off;
      else            clen = (rem < LINE) ? rem : LINE;
      waitN = 0;
      while (!reqValid && waitN < 50) begin @(negedge clk); waitN++; end
      chk(reqValid, "R7", "request presented", longint'(reqValid), 1);
      chk(reqPhysAddr == AW'(addr + doneB), (doneB == 0) ? "R2" : "R4", "phys addr",
          longint'(reqPhysAddr), longint'(addr + doneB));
      chk(reqLineAddr == AW'((addr + doneB) & ~(LINE - 1)), "R2", "line addr",
          longint'(reqLineAddr), longint'((addr + doneB) & ~(LINE - 1)));
      chk(reqOffset == LB'(off), (doneB == 0) ? "R2" : "R4", "offset",
          longint'(reqOffset), longint'(off));
      chk(reqLen == (LB+1)'(clen), (doneB == 0) ? "R3" : "R4", "chunk len",
          longint'(reqLen), longint'(clen));
      chk(reqWrite == wr, "R11", "direction", longint'(reqWrite), longint'(wr));
      if (wr) begin
        bad = 0;
        for (int j = 0; j < LINE; j++) begin
          logic [7:0] e;
          e = (j >= off && j < off + clen) ? pay[doneB + j - off] : 8'h00;
          if (reqData[j*8 +: 8] != e) bad++;
        end
        chk(bad == 0, "R5", "write line bytes wrong", longint'(bad), 0);
      end
      sPhys = reqPhysAddr; sLen = reqLen; sData = reqData;
      for (int s = 0; s < stall; s++) @(negedge clk);
      if (stall > 0)
        chk(reqValid && reqPhysAddr == sPhys && reqLen == sLen && reqData == sData,
            "R8", "held request changed", longint'(reqPhysAddr), longint'(sPhys));
      reqReady = 1'b1;
      @(negedge clk);
      reqReady = 1'b0;
      chk(!reqValid, "R7", "request dropped after accept", longint'(reqValid), 0);
      lineA = (addr + doneB) & ~(LINE - 1);
      if (wr)
        for (int j = off; j < off + clen; j++) memModel[12'(lineA + j)] = sData[j*8 +: 8];
      for (int g = 0; g < gap; g++) @(negedge clk);
      chk(!reqValid && rspReady, "R7", "waiting for response",
          longint'({reqValid, rspReady}), 1);
      for (int j = 0; j < LINE; j++) rspData[j*8 +: 8] = memModel[12'(lineA + j)];
      rspIsData = !wr;
      rspValid  = 1'b1;
      @(negedge clk);
      rspValid = 1'b0;
      doneB += clen;
      if (doneB >= len)
        chk(donePulse && !busy, "R9", "done pulse with idle",
            longint'({donePulse, busy}), 2);
      else
        chk(!donePulse && busy, "R9", "no early done", longint'({donePulse, busy}), 1);
    end
    if (!wr) begin
      bad = 0;
      for (int k = 0; k < len; k++)
        if (xferBuf[k*8 +: 8] != memModel[12'(addr + k)]) bad++;
      chk(bad == 0, "R6", "read buffer bytes wrong", longint'(bad), 0);
    end else begin
      bad = 0;
      for (int k = 0; k < len; k++)
        if (memModel[12'(addr + k)] != pay[k]) bad++;
      chk(bad == 0, "R5", "written bytes wrong", longint'(bad), 0);
      chk(memModel[12'(addr - 1)] == snapLo && memModel[12'(addr + len)] == snapHi,
          "R5", "neighbour bytes disturbed", longint'(memModel[12'(addr + len)]),
          longint'(snapHi));
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && xferReady && !reqValid && !donePulse && !rspReady, "R1", "reset state",
        longint'({busy, xferReady, reqValid, donePulse, rspReady}), 8);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReadMidLine();   // off 5: chunks 59, 64, 2
    startXfer(32'h105, 125, 1'b0, 1);
    serveAll(32'h105, 125, 1'b0, 0, 1);
  endtask

  task automatic testReadFits();      // single chunks, incl. offset+len == line
    startXfer(32'h210, 20, 1'b0, 2);
    serveAll(32'h210, 20, 1'b0, 2, 0);
    startXfer(32'h230, 16, 1'b0, 3);
    serveAll(32'h230, 16, 1'b0, 0, 2);
  endtask

  task automatic testWriteMidLine();  // off 58: chunks 6, 64, 20
    startXfer(32'h33A, 90, 1'b1, 7);
    serveAll(32'h33A, 90, 1'b1, 3, 2);
  endtask

  task automatic testWriteFull();     // aligned, max length: 64, 64
    startXfer(32'h400, 128, 1'b1, 9);
    serveAll(32'h400, 128, 1'b1, 1, 0);
  endtask

  task automatic testZeroLen();
    startXfer(32'h777, 0, 1'b1, 4);
    chk(donePulse && !busy, "R10", "zero length done", longint'({donePulse, busy}), 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!reqValid && !busy && !donePulse, "R10", "nothing issued",
          longint'({reqValid, busy, donePulse}), 0);
    end
  endtask

  task automatic testBackToBack();    // read A, write B queued behind it
    startXfer(32'h500, 10, 1'b0, 5);
    setXfer(32'h6F0, 30, 1'b1, 11);
    @(negedge clk);
    chk(!xferReady && busy, "R1", "second transfer held off",
        longint'({xferReady, busy}), 1);
    chk(reqPhysAddr == AW'(32'h500), "R1", "first request unchanged",
        longint'(reqPhysAddr), 32'h500);
    serveAll(32'h500, 10, 1'b0, 1, 1);
    chk(xferReady, "R1", "ready in done cycle", longint'(xferReady), 1);
    @(negedge clk);
    xferValid = 1'b0;
    chk(busy && !donePulse, "R1", "second taken at done edge",
        longint'({busy, donePulse}), 2);
    serveAll(32'h6F0, 30, 1'b1, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) memModel[i] = 8'(i * 7 + 3);
    testReset();
    testReadMidLine();
    testReadFits();
    testWriteMidLine();
    testWriteFull();
    testZeroLen();
    testBackToBack();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule